// File: doc/BRIEF.md
# Pixel Format Decoder with Colour Palette

This block turns one incoming pixel word per clock into an 8-bit red, green and blue triple. A small configuration port sets the pixel format, a lookup mask and the output width of the palette. The same port loads a 256-entry colour palette. The supported formats are 8 bits per pixel indexed colour, 16 bits per pixel in 5-6-5 or 5-5-5 packing, and 24 bits per pixel. In the 16 and 24 bit formats each channel field is either looked up in the palette or expanded and passed straight through.

A palette entry is loaded in two steps. Software first writes the entry number to the address register. It then writes three bytes to the data register, in the order red, green, blue. The entry is stored when the third byte arrives. The address then steps on to the next entry, so a whole palette can be streamed after one address write. Each pixel result appears one clock after the pixel is presented, with a valid flag that tracks the input valid.

Top module: `pixel_colour_expander`

## Requirements
- R1: `out_valid` equals `pix_valid` delayed by one clock. The colour outputs take a new value only on the clock edge after a cycle with `pix_valid` high, and hold their value otherwise. Reset clears `out_valid` and all colour outputs to 0.
- R2: A configuration write happens in a cycle with `cfg_we` high. `cfg_sel` picks the target: 0 is the palette address, 1 is palette data, 2 is the index mask and 3 is the mode byte. Successive data writes supply red, then green, then blue. The entry at the current address is stored when the blue byte arrives. The palette address resets to 0.
- R3: After a blue byte the palette address increments by one, wrapping from 255 to 0. A write to the address register drops any partly written triplet, and the next data byte is taken as red.
- R4: Mode byte layout:
  - Bits 7:5 select the format: 000 is 24 bpp, 001 is 16 bpp, 010 is 8 bpp. Every other code is unsupported.
  - Bit 4 selects bypass.
  - Bit 3 selects 5-6-5 packing in 16 bpp.
  - Bit 1 selects the 8-bit palette output.
  - All other bits are ignored. The mode byte resets to 0x00.
- R5: In 8 bpp, palette entry (`pix_data[7:0]` AND mask) drives all three channels. The mask resets to 0xFF. Bits 23:8 and the bypass bit have no effect.
- R6: Every channel value taken from the palette is output as the stored byte when mode bit 1 is 1. When mode bit 1 is 0, the low six bits of the stored byte are output shifted left by two.
- R7: In 24 bpp with bypass, red is `pix_data[23:16]`, green is `pix_data[15:8]` and blue is `pix_data[7:0]`. They are output unchanged and mode bit 1 has no effect.
- R8: In 24 bpp without bypass, each byte of the pixel is ANDed with the mask. The result indexes the palette, and the output channel takes that channel's component of the indexed entry.
- R9: In 16 bpp 5-6-5 with bypass, the fields are red [15:11], green [10:5] and blue [4:0]. Each field is widened to 8 bits by appending its own top bits.
- R10: In 16 bpp 5-5-5 with bypass, the fields are red [14:10], green [9:5] and blue [4:0], widened the same way. Bit 15 is ignored.
- R11: In 16 bpp without bypass, each field is placed at the top of an 8-bit index, with the low bits zero. The index is ANDed with the mask and looked up per channel, as in R8. Bits 23:16 are ignored.
- R12: With an unsupported format code, the colour result is 0. `out_valid` still follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 8 | Configuration write byte |
| pix_valid | input | 1 | Pixel word present |
| pix_data | input | 24 | Pixel word |
| out_valid | output | 1 | Colour result present |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
A pixel presented in one cycle yields its colour and valid flag on the next rising edge. A configuration write, including the blue byte that stores a palette entry, is in force for any pixel presented after that write's edge. The bench drives every input on the falling edge and holds it for exactly one rising edge. It then reads the outputs on the following falling edge, so each check sees the result due for that stimulus and no other. The hold check waits several idle cycles before reading, to confirm that the outputs did not move.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
  localparam int CH_W  = 8;
  localparam int NCH   = 3;
  localparam int PIX_W = NCH * CH_W;
  localparam int IDX_W = CH_W;

  localparam logic [2:0] FMT_24 = 3'b000;
  localparam logic [2:0] FMT_16 = 3'b001;
  localparam logic [2:0] FMT_8  = 3'b010;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;

  typedef struct packed {
    logic [2:0] fmt;
    logic       bypass;
    logic       w565;
    logic       dac8;
  } mode_t;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // widen a 5-bit field by repeating its upper bits into the gap
  function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // palette output width: full byte, or six bits placed at the top
  function automatic logic [CH_W-1:0] dac_scale(input logic [CH_W-1:0] v, input logic full);
    return full ? v : {v[5:0], 2'b00};
  endfunction
endpackage

// File: rtl/pxd_palette.sv
module pxd_palette
  import pxd_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           addr_we,
  input  logic                           data_we,
  input  logic [CH_W-1:0]                wdata,
  input  logic [NCH-1:0][IDX_W-1:0]      rd_idx,
  output logic [NCH-1:0][CH_W-1:0]       rd_val
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0] wr_ptr;
  logic [1:0]       phase;
  logic [CH_W-1:0]  hold_r;
  logic [CH_W-1:0]  hold_g;
  logic             commit;
  rgb_t             mem [ENTRIES];

  assign commit = data_we && (phase == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      phase  <= 2'd0;
      hold_r <= '0;
      hold_g <= '0;
    end else if (addr_we) begin
      wr_ptr <= wdata[IDX_W-1:0];
      phase  <= 2'd0;
    end else if (data_we) begin
      case (phase)
        2'd0: begin hold_r <= wdata; phase <= 2'd1; end
        2'd1: begin hold_g <= wdata; phase <= 2'd2; end
        default: begin wr_ptr <= wr_ptr + IDX_W'(1); phase <= 2'd0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[wr_ptr] <= '{r: hold_r, g: hold_g, b: wdata};
  end

  // one read port per channel, each returning only its own component
  for (genvar c = 0; c < NCH; c++) begin : g_rd
    rgb_t ent;
    assign ent = mem[rd_idx[c]];
    if (c == 0) begin : g_red
      assign rd_val[c] = ent.r;
    end else if (c == 1) begin : g_grn
      assign rd_val[c] = ent.g;
    end else begin : g_blu
      assign rd_val[c] = ent.b;
    end
  end

  a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
  a_r3_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (wr_ptr == $past(wr_ptr) + IDX_W'(1)) && (phase == 2'd0));
  a_r3_addr_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (phase == 2'd0) && (wr_ptr == $past(wdata[IDX_W-1:0])));
endmodule

// File: rtl/pxd_index_gen.sv
module pxd_index_gen
  import pxd_pkg::*;
(
  input  mode_t                      mode,
  input  logic [IDX_W-1:0]           mask,
  input  logic [PIX_W-1:0]           pix,
  output logic [NCH-1:0][IDX_W-1:0]  idx
);
  logic [NCH-1:0][IDX_W-1:0] raw;

  always_comb begin
    case (mode.fmt)
      FMT_8: begin
        raw[0] = pix[7:0];
        raw[1] = pix[7:0];
        raw[2] = pix[7:0];
      end
      FMT_16: begin
        if (mode.w565) begin
          raw[0] = {pix[15:11], 3'b000};
          raw[1] = {pix[10:5],  2'b00};
        end else begin
          raw[0] = {pix[14:10], 3'b000};
          raw[1] = {pix[9:5],   3'b000};
        end
        raw[2] = {pix[4:0], 3'b000};
      end
      default: begin
        raw[0] = pix[23:16];
        raw[1] = pix[15:8];
        raw[2] = pix[7:0];
      end
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mask
    assign idx[c] = raw[c] & mask;
  end
endmodule

// File: rtl/pxd_colour_sel.sv
module pxd_colour_sel
  import pxd_pkg::*;
(
  input  mode_t                     mode,
  input  logic [PIX_W-1:0]          pix,
  input  logic [NCH-1:0][CH_W-1:0]  pal_val,
  output rgb_t                      colour
);
  rgb_t from_pal;
  rgb_t direct24;
  rgb_t direct16;

  assign from_pal = '{r: dac_scale(pal_val[0], mode.dac8),
                      g: dac_scale(pal_val[1], mode.dac8),
                      b: dac_scale(pal_val[2], mode.dac8)};

  assign direct24 = '{r: pix[23:16], g: pix[15:8], b: pix[7:0]};

  always_comb begin
    if (mode.w565)
      direct16 = '{r: widen5(pix[15:11]), g: widen6(pix[10:5]), b: widen5(pix[4:0])};
    else
      direct16 = '{r: widen5(pix[14:10]), g: widen5(pix[9:5]),  b: widen5(pix[4:0])};
  end

  always_comb begin
    case (mode.fmt)
      FMT_24:  colour = mode.bypass ? direct24 : from_pal;
      FMT_16:  colour = mode.bypass ? direct16 : from_pal;
      FMT_8:   colour = from_pal;
      default: colour = '0;
    endcase
  end
endmodule

// File: rtl/pixel_colour_expander.sv
module pixel_colour_expander
  import pxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CH_W-1:0]   cfg_wdata,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_r,
  output logic [CH_W-1:0]   out_g,
  output logic [CH_W-1:0]   out_b
);
  mode_t                     mode_q;
  logic [IDX_W-1:0]          mask_q;
  logic [NCH-1:0][IDX_W-1:0] idx;
  logic [NCH-1:0][CH_W-1:0]  pal_val;
  rgb_t                      colour;
  rgb_t                      out_q;
  logic                      valid_q;
  logic                      addr_we;
  logic                      data_we;
  logic                      fmt_unsupported;

  assign addr_we = cfg_we && (cfg_sel == SEL_ADDR);
  assign data_we = cfg_we && (cfg_sel == SEL_DATA);
  assign fmt_unsupported = (mode_q.fmt != FMT_24) && (mode_q.fmt != FMT_16) && (mode_q.fmt != FMT_8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '1;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_MASK) mask_q <= cfg_wdata[IDX_W-1:0];
      if (cfg_sel == SEL_MODE)
        mode_q <= '{fmt: cfg_wdata[7:5], bypass: cfg_wdata[4], w565: cfg_wdata[3], dac8: cfg_wdata[1]};
    end
  end

  pxd_palette u_pal (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_we (addr_we),
    .data_we (data_we),
    .wdata   (cfg_wdata),
    .rd_idx  (idx),
    .rd_val  (pal_val)
  );

  pxd_index_gen u_idx (
    .mode (mode_q),
    .mask (mask_q),
    .pix  (pix_data),
    .idx  (idx)
  );

  pxd_colour_sel u_sel (
    .mode    (mode_q),
    .pix     (pix_data),
    .pal_val (pal_val),
    .colour  (colour)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= pix_valid;
      if (pix_valid) out_q <= colour;
    end
  end

  assign out_valid = valid_q;
  assign out_r = out_q.r;
  assign out_g = out_q.g;
  assign out_b = out_q.b;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(out_r) && $stable(out_g) && $stable(out_b));
  a_r12_black: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && fmt_unsupported) |=> (out_r == '0) && (out_g == '0) && (out_b == '0));
  a_r7_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mode_q.fmt == FMT_24 && mode_q.bypass) |=>
      ({out_r, out_g, out_b} == $past(pix_data)));
endmodule

// File: tb/sim_pixel_colour_expander.sv
`timescale 1ns/1ps
module sim_pixel_colour_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = 24'd0;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] sh_r [256];
  logic [7:0] sh_g [256];
  logic [7:0] sh_b [256];

  always #4 clk = ~clk;

  pixel_colour_expander u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  function automatic logic [7:0] ex5(input int x);
    return 8'(((x << 3) | (x >> 2)) & 255);
  endfunction
  function automatic logic [7:0] ex6(input int x);
    return 8'(((x << 2) | (x >> 4)) & 255);
  endfunction
  function automatic logic [7:0] dacx(input logic [7:0] v, input bit full);
    return full ? v : 8'((int'(v) * 4) & 255);
  endfunction

  task automatic check_rgb(input string tag, input logic [7:0] er, input logic [7:0] eg, input logic [7:0] eb);
    total++;
    if (out_valid !== 1'b1 || out_r !== er || out_g !== eg || out_b !== eb) begin
      fails++;
      $display("FAIL %s actual v=%b rgb=%02h%02h%02h expected v=1 rgb=%02h%02h%02h",
               tag, out_valid, out_r, out_g, out_b, er, eg, eb);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R4 layout: fmt[7:5] bypass[4] 565[3] dac8[1]
  task automatic set_mode(input logic [2:0] fmt, input bit byp, input bit w565, input bit dac8);
    cfg(2'd3, {fmt, byp, w565, 1'b0, dac8, 1'b0});
  endtask

  task automatic send(input logic [23:0] d);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = d;
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic t_reset;
    total++;
    if (out_valid !== 1'b0 || {out_r, out_g, out_b} !== 24'h0) begin
      fails++;
      $display("FAIL R1 reset actual v=%b rgb=%06h expected v=0 rgb=000000", out_valid, {out_r, out_g, out_b});
    end
  endtask

  task automatic t_load_all;
    cfg(2'd0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      sh_r[i] = 8'(i); sh_g[i] = 8'(255 - i); sh_b[i] = 8'((i * 7 + 3) & 255);
      cfg(2'd1, sh_r[i]); cfg(2'd1, sh_g[i]); cfg(2'd1, sh_b[i]);
    end
  endtask

  task automatic t_8bpp;
    set_mode(3'b010, 0, 0, 1);
    send(24'h000000); check_rgb("R2 R5 idx00", sh_r[0], sh_g[0], sh_b[0]);
    send(24'h00007F); check_rgb("R3 R5 idx7F", sh_r[8'h7F], sh_g[8'h7F], sh_b[8'h7F]);
    send(24'hABCDFF); check_rgb("R5 high bits ignored", sh_r[8'hFF], sh_g[8'hFF], sh_b[8'hFF]);
    set_mode(3'b010, 1, 0, 1);
    send(24'h123456); check_rgb("R5 bypass ignored", sh_r[8'h56], sh_g[8'h56], sh_b[8'h56]);
    cfg(2'd2, 8'h0F);
    send(24'h0000AB); check_rgb("R5 mask", sh_r[8'h0B], sh_g[8'h0B], sh_b[8'h0B]);
    cfg(2'd2, 8'hFF);
  endtask

  task automatic t_dac6;
    set_mode(3'b010, 0, 0, 0);
    send(24'h000093);
    check_rgb("R6 six-bit", dacx(sh_r[8'h93], 0), dacx(sh_g[8'h93], 0), dacx(sh_b[8'h93], 0));
  endtask

  task automatic t_24;
    set_mode(3'b000, 1, 0, 0);
    send(24'h1A2B3C); check_rgb("R7 direct", 8'h1A, 8'h2B, 8'h3C);
    set_mode(3'b000, 0, 0, 1);
    send(24'h10C0F3); check_rgb("R8 per channel", sh_r[8'h10], sh_g[8'hC0], sh_b[8'hF3]);
  endtask

  task automatic t_16;
    int p;
    set_mode(3'b001, 1, 1, 1);
    p = 16'hF81F; send(24'hFF0000 | 24'(p));
    check_rgb("R9 565 a", ex5((p >> 11) & 31), ex6((p >> 5) & 63), ex5(p & 31));
    p = 16'h07E0; send(24'(p));
    check_rgb("R9 565 b", ex5((p >> 11) & 31), ex6((p >> 5) & 63), ex5(p & 31));
    set_mode(3'b001, 1, 0, 1);
    p = 16'hFC00; send(24'(p));
    check_rgb("R10 555 bit15", ex5((p >> 10) & 31), ex5((p >> 5) & 31), ex5(p & 31));
    p = 16'h2D6B; send(24'(p));
    check_rgb("R10 555", ex5((p >> 10) & 31), ex5((p >> 5) & 31), ex5(p & 31));
    set_mode(3'b001, 0, 1, 1);
    p = 16'hA5C3; send(24'h770000 | 24'(p));
    check_rgb("R11 565 pal", sh_r[((p >> 11) & 31) << 3], sh_g[((p >> 5) & 63) << 2], sh_b[(p & 31) << 3]);
    set_mode(3'b001, 0, 0, 1);
    p = 16'hD4B2; send(24'(p));
    check_rgb("R11 555 pal", sh_r[((p >> 10) & 31) << 3], sh_g[((p >> 5) & 31) << 3], sh_b[(p & 31) << 3]);
  endtask

  task automatic t_unsupported;
    set_mode(3'b011, 1, 0, 1); send(24'hFFFFFF); check_rgb("R12 R4 code3", 8'h00, 8'h00, 8'h00);
    set_mode(3'b100, 0, 0, 1); send(24'hFFFFFF); check_rgb("R12 R4 code4", 8'h00, 8'h00, 8'h00);
    set_mode(3'b111, 1, 1, 1); send(24'hFFFFFF); check_rgb("R12 R4 code7", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_wrap;
    cfg(2'd0, 8'hFF);
    cfg(2'd1, 8'h11); cfg(2'd1, 8'h22); cfg(2'd1, 8'h33);
    cfg(2'd1, 8'h44); cfg(2'd1, 8'h55); cfg(2'd1, 8'h66);
    sh_r[255] = 8'h11; sh_g[255] = 8'h22; sh_b[255] = 8'h33;
    sh_r[0] = 8'h44; sh_g[0] = 8'h55; sh_b[0] = 8'h66;
    set_mode(3'b010, 0, 0, 1);
    send(24'h0000FF); check_rgb("R3 entry255", 8'h11, 8'h22, 8'h33);
    send(24'h000000); check_rgb("R3 wrap to 0", 8'h44, 8'h55, 8'h66);
  endtask

  task automatic t_restart;
    cfg(2'd0, 8'h05); cfg(2'd1, 8'hEE);
    cfg(2'd0, 8'h06); cfg(2'd1, 8'h01); cfg(2'd1, 8'h02); cfg(2'd1, 8'h03);
    sh_r[6] = 8'h01; sh_g[6] = 8'h02; sh_b[6] = 8'h03;
    send(24'h000005); check_rgb("R3 partial dropped", sh_r[5], sh_g[5], sh_b[5]);
    send(24'h000006); check_rgb("R3 restart as red", 8'h01, 8'h02, 8'h03);
  endtask

  task automatic t_hold;
    set_mode(3'b000, 1, 0, 1);
    send(24'h5A6B7C);
    pix_data = 24'h010203;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || {out_r, out_g, out_b} !== 24'h5A6B7C) begin
      fails++;
      $display("FAIL R1 hold actual v=%b rgb=%06h expected v=0 rgb=5a6b7c", out_valid, {out_r, out_g, out_b});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_all();
    t_8bpp();
    t_dac6();
    t_24();
    t_16();
    t_unsupported();
    t_wrap();
    t_restart();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule